// File: doc/BRIEF.md
# Block Protection State Keeper

This unit keeps a protection state for every erase block of a 2M-word flash array, where a few small parameter blocks sit at one end of the address space and the large main blocks fill the rest. Each block is open, held (locked), or pinned (locked and locked-down). Requests arrive as an operation code plus any word address inside the target block. The unit resolves the block, applies the write-protect pin rule to the request, and stores the new state on the next clock edge.

A separate query address is answered combinationally. One output says whether a program or erase may go ahead at that address. It is true only when the block is open and the program supply is above its lockout level. The other output gives the two status bits that an identifier read returns for that block. The layout, top-boot or bottom-boot, is chosen with an elaboration parameter.

Top module: `lock_guard`

## Requirements
- R1: With `TOP_BOOT=1`, word addresses 1F8000h to 1FFFFFh form eight 4K-word blocks. Addresses 000000h to 1F7FFFh form 63 blocks of 32K words. A request changes only the block that contains its address.
- R2: With `TOP_BOOT=0`, word addresses 000000h to 007FFFh form eight 4K-word blocks. Addresses 008000h to 1FFFFFh form 63 blocks of 32K words. A request changes only the block that contains its address.
- R3: Synchronous reset puts every block in the held state, including blocks that were pinned.
- R4: `qry_writable` is 1 only when the queried block is open and `vpp_ok` is 1. When `vpp_ok` is 0 it is 0 for every block.
- R5: A lock request (`req_op`=1) moves an open block to held and leaves a held or pinned block unchanged.
- R6: A lock-down request (`req_op`=3) moves any block to pinned, whatever the level of `wr_prot`.
- R7: An unlock request (`req_op`=2) while `wr_prot` is 1 moves any block, pinned included, to open.
- R8: An unlock request while `wr_prot` is 0 opens a held or open block and is ignored for a pinned block.
- R9: `qry_status` bit 0 is the lock flag and bit 1 is the lock-down flag: 00 for open, 01 for held, 11 for pinned. 10 never appears.
- R10: A request takes effect on the rising edge where `req_valid` is 1 and is visible at the query outputs after that edge. With `req_valid` at 0, or with `req_op`=0, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 none, 1 lock, 2 unlock, 3 lock-down |
| req_addr | input | 21 | Any word address inside the target block |
| wr_prot | input | 1 | Write-protect level; 1 lifts lock-down |
| vpp_ok | input | 1 | Program supply above lockout |
| qry_addr | input | 21 | Address under inspection |
| qry_writable | output | 1 | Program/erase allowed at qry_addr |
| qry_status | output | 2 | {lock-down, lock} flags of the queried block |

## Verification
The bench builds two copies with the default sizes: 21 address bits, eight 4K-word parameter blocks and 32K-word main blocks. One copy uses `TOP_BOOT=1` and the other `TOP_BOOT=0`, and both receive the same stimulus. Because both layouts are present, a single request lands in a parameter block in one copy and in a main block in the other. This makes the mirrored edges (1F7FFFh/1F8000h, 007FFFh/008000h, and the 4K steps inside the parameter region) observable at the query port. It also allows a sweep over all 71 blocks of each layout.

// File: rtl/lock_guard_pkg.sv
package lock_guard_pkg;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'b00,
        LK_HELD   = 2'b01,
        LK_PINNED = 2'b11
    } lk_state_e;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_LOCK   = 2'd1,
        OP_UNLOCK = 2'd2,
        OP_PIN    = 2'd3
    } lk_op_e;

    function automatic lk_state_e lk_next(lk_state_e cur, lk_op_e op, logic wp_high);
        lk_state_e nxt;
        nxt = cur;
        case (op)
            OP_LOCK:   if (cur == LK_OPEN) nxt = LK_HELD;
            OP_PIN:    nxt = LK_PINNED;
            OP_UNLOCK: if (cur != LK_PINNED || wp_high) nxt = LK_OPEN;
            default:   nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/blk_decode.sv
module blk_decode #(
    parameter int ADDR_W       = 21,
    parameter int PARAM_W      = 12,
    parameter int MAIN_W       = 15,
    parameter int PARAM_BLOCKS = 8,
    parameter int IDX_W        = 7,
    parameter bit TOP_BOOT     = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam logic [ADDR_W:0]   FULL     = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W:0]   SPAN_W   = (ADDR_W+1)'(PARAM_BLOCKS) << PARAM_W;
    localparam logic [ADDR_W-1:0] SPAN     = SPAN_W[ADDR_W-1:0];
    localparam logic [ADDR_W:0]   TBASE_W  = FULL - SPAN_W;
    localparam logic [ADDR_W-1:0] TOP_BASE = TBASE_W[ADDR_W-1:0];
    localparam int                NUM_MAIN = int'((FULL - SPAN_W) >> MAIN_W);

    logic [ADDR_W-1:0] off;

    generate
        if (TOP_BOOT) begin : g_top
            always_comb begin
                off = addr - TOP_BASE;
                if (addr >= TOP_BASE)
                    idx = IDX_W'(NUM_MAIN) + IDX_W'(off >> PARAM_W);
                else
                    idx = IDX_W'(addr >> MAIN_W);
            end
        end else begin : g_bottom
            always_comb begin
                off = addr - SPAN;
                if (addr < SPAN)
                    idx = IDX_W'(addr >> PARAM_W);
                else
                    idx = IDX_W'(PARAM_BLOCKS) + IDX_W'(off >> MAIN_W);
            end
        end
    endgenerate
endmodule

// File: rtl/lock_cell.sv
module lock_cell
    import lock_guard_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hit,
    input  lk_op_e    op,
    input  logic      wp_high,
    output lk_state_e state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= LK_HELD;
        else if (hit)
            state <= lk_next(state, op, wp_high);
    end
endmodule

// File: rtl/lock_guard.sv
module lock_guard
    import lock_guard_pkg::*;
#(
    parameter int ADDR_W       = 21,
    parameter int PARAM_W      = 12,
    parameter int MAIN_W       = 15,
    parameter int PARAM_BLOCKS = 8,
    parameter bit TOP_BOOT     = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_prot,
    input  logic              vpp_ok,
    input  logic [ADDR_W-1:0] qry_addr,
    output logic              qry_writable,
    output logic [1:0]        qry_status
);
    localparam int NUM_MAIN   = ((1 << ADDR_W) - (PARAM_BLOCKS << PARAM_W)) >> MAIN_W;
    localparam int NUM_BLOCKS = NUM_MAIN + PARAM_BLOCKS;
    localparam int IDX_W      = $clog2(NUM_BLOCKS);

    logic [IDX_W-1:0] req_idx, qry_idx;
    lk_state_e        blk_st [NUM_BLOCKS];
    lk_state_e        sel_st;
    lk_op_e           op_q;

    assign op_q = lk_op_e'(req_op);

    blk_decode #(
        .ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .MAIN_W(MAIN_W),
        .PARAM_BLOCKS(PARAM_BLOCKS), .IDX_W(IDX_W), .TOP_BOOT(TOP_BOOT)
    ) u_req_dec (.addr(req_addr), .idx(req_idx));

    blk_decode #(
        .ADDR_W(ADDR_W), .PARAM_W(PARAM_W), .MAIN_W(MAIN_W),
        .PARAM_BLOCKS(PARAM_BLOCKS), .IDX_W(IDX_W), .TOP_BOOT(TOP_BOOT)
    ) u_qry_dec (.addr(qry_addr), .idx(qry_idx));

    generate
        for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cell
            lock_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .hit     (req_valid && (req_idx == IDX_W'(b))),
                .op      (op_q),
                .wp_high (wr_prot),
                .state   (blk_st[b])
            );
        end
    endgenerate

    always_comb begin
        sel_st = LK_HELD;
        for (int b = 0; b < NUM_BLOCKS; b++)
            if (qry_idx == IDX_W'(b)) sel_st = blk_st[b];
    end

    assign qry_status   = sel_st;
    assign qry_writable = vpp_ok && (sel_st == LK_OPEN);
endmodule

// File: rtl/lock_guard_chk.sv
module lock_guard_chk #(
    parameter int ADDR_W = 21
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [ADDR_W-1:0] req_addr,
    input logic              wr_prot,
    input logic              vpp_ok,
    input logic [ADDR_W-1:0] qry_addr,
    input logic              qry_writable,
    input logic [1:0]        qry_status
);
    logic seen_rst;
    always_ff @(posedge clk) seen_rst <= rst ? 1'b1 : seen_rst;

    // R3: first cycle out of reset every block reads held
    a_r3_reset_held: assert property (@(posedge clk) disable iff (rst)
        (seen_rst && $past(rst)) |-> qry_status == 2'b01);

    // R4
    a_r4_write_gate: assert property (@(posedge clk) disable iff (rst)
        qry_writable |-> (vpp_ok && qry_status == 2'b00));

    // R9
    a_r9_no_bare_down: assert property (@(posedge clk) disable iff (rst)
        seen_rst |-> qry_status != 2'b10);

    // R6
    a_r6_pin_applies: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd3 && qry_addr == req_addr)
        |=> (qry_addr != $past(qry_addr) || qry_status == 2'b11));

    // R8
    a_r8_pin_kept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2 && !wr_prot && qry_addr == req_addr && qry_status == 2'b11)
        |=> (qry_addr != $past(qry_addr) || qry_status == 2'b11));

    // R7
    a_r7_unlock_open: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 2'd2 && wr_prot && qry_addr == req_addr)
        |=> (qry_addr != $past(qry_addr) || qry_status == 2'b00));
endmodule

bind lock_guard lock_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .wr_prot(wr_prot), .vpp_ok(vpp_ok),
    .qry_addr(qry_addr), .qry_writable(qry_writable), .qry_status(qry_status)
);

// File: tb/lock_guard_tb.sv
module lock_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 71;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [20:0] req_addr = '0;
    logic        wr_prot = 1'b0;
    logic        vpp_ok = 1'b1;
    logic [20:0] qry_addr = '0;
    logic        wr_t, wr_b;
    logic [1:0]  st_t, st_b;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [1:0] m_t [NB];
    logic [1:0] m_b [NB];

    always #(CLK_PERIOD/2) clk = ~clk;

    lock_guard #(.TOP_BOOT(1'b1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .wr_prot(wr_prot), .vpp_ok(vpp_ok),
        .qry_addr(qry_addr), .qry_writable(wr_t), .qry_status(st_t));

    lock_guard #(.TOP_BOOT(1'b0)) u_dut_bb (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .wr_prot(wr_prot), .vpp_ok(vpp_ok),
        .qry_addr(qry_addr), .qry_writable(wr_b), .qry_status(st_b));

    function automatic int bi_top(logic [20:0] a);
        if (a[20:15] == 6'h3F) return 63 + int'(a[14:12]);
        return int'(a[20:15]);
    endfunction

    function automatic int bi_bot(logic [20:0] a);
        if (a[20:15] == 6'h00) return int'(a[14:12]);
        return 7 + int'(a[20:15]);
    endfunction

    function automatic logic [1:0] mnext(logic [1:0] s, logic [1:0] op, logic wp);
        if (op == 2'd1) return (s == 2'b00) ? 2'b01 : s;
        if (op == 2'd3) return 2'b11;
        if (op == 2'd2) return (s == 2'b11 && !wp) ? s : 2'b00;
        return s;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%h actual=%0h expected=%0h", tag, qry_addr, act, exp);
        end
    endtask

    task automatic look(logic [20:0] a, string tag);
        logic [1:0] et, eb;
        qry_addr = a;
        #1;
        et = m_t[bi_top(a)];
        eb = m_b[bi_bot(a)];
        chk({tag, " top status"}, 32'(st_t), 32'(et));
        chk({tag, " bot status"}, 32'(st_b), 32'(eb));
        chk({tag, " top writable"}, 32'(wr_t), 32'(vpp_ok && et == 2'b00));
        chk({tag, " bot writable"}, 32'(wr_b), 32'(vpp_ok && eb == 2'b00));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NB; i++) begin m_t[i] = 2'b01; m_b[i] = 2'b01; end
    endtask

    task automatic req(logic [1:0] op, logic [20:0] a, logic wp, logic v = 1'b1);
        @(negedge clk);
        req_valid = v; req_op = op; req_addr = a; wr_prot = wp;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (v) begin
            m_t[bi_top(a)] = mnext(m_t[bi_top(a)], op, wp);
            m_b[bi_bot(a)] = mnext(m_b[bi_bot(a)], op, wp);
        end
    endtask

    task automatic t_reset_state();
        do_reset();
        look(21'h000000, "R3 reset");
        look(21'h1FFFFF, "R3 reset");
        look(21'h0A1234, "R3 reset");
    endtask

    task automatic t_top_edges();
        req(2'd2, 21'h1F8000, 1'b0);
        look(21'h1F8000, "R1 param lo");
        look(21'h1F8FFF, "R1 param end");
        look(21'h1F9000, "R1 next param");
        look(21'h1F7FFF, "R1 last main");
        req(2'd2, 21'h1F0000, 1'b0);
        look(21'h1F7FFF, "R1 main 62");
        look(21'h1EFFFF, "R1 main 61");
    endtask

    task automatic t_bot_edges();
        req(2'd2, 21'h000FFF, 1'b0);
        look(21'h000000, "R2 param0");
        look(21'h001000, "R2 param1");
        req(2'd2, 21'h008000, 1'b0);
        look(21'h00FFFF, "R2 main0 end");
        look(21'h007FFF, "R2 param7");
        look(21'h010000, "R2 main1");
    endtask

    task automatic t_lock_and_pin();
        req(2'd1, 21'h000FFF, 1'b1);
        look(21'h000FFF, "R5 lock open");
        req(2'd3, 21'h1F8000, 1'b1);
        look(21'h1F8000, "R6 pin wp high");
        req(2'd1, 21'h1F8000, 1'b0);
        look(21'h1F8000, "R5 lock on pinned");
        req(2'd3, 21'h040000, 1'b0);
        look(21'h040000, "R6 pin wp low");
    endtask

    task automatic t_unlock_rules();
        req(2'd2, 21'h040000, 1'b0);
        look(21'h040000, "R8 pinned kept");
        req(2'd2, 21'h0C0000, 1'b0);
        look(21'h0C0000, "R8 held opened");
        req(2'd2, 21'h040000, 1'b1);
        look(21'h040000, "R7 pinned opened");
    endtask

    task automatic t_idle();
        req(2'd3, 21'h100000, 1'b1, 1'b0);
        look(21'h100000, "R10 valid low");
        req(2'd0, 21'h0C0000, 1'b1);
        look(21'h0C0000, "R10 op none");
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 21'h180000; wr_prot = 1'b0;
        qry_addr = 21'h180000;
        #1;
        chk("R10 before edge", 32'(st_t), 32'(2'b01));
        req_valid = 1'b0;
    endtask

    task automatic t_vpp();
        vpp_ok = 1'b0;
        look(21'h0C0000, "R4 vpp low");
        look(21'h1F8000, "R4 vpp low");
        vpp_ok = 1'b1;
        look(21'h0C0000, "R4 vpp high");
    endtask

    task automatic t_reset_pinned();
        req(2'd3, 21'h1FF000, 1'b0);
        look(21'h1FF000, "R9 pinned bits");
        do_reset();
        look(21'h1FF000, "R3 pinned to held");
        look(21'h040000, "R3 open to held");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < NB; i += 3) req(2'd2, (i < 63) ? 21'(i << 15) : 21'(21'h1F8000 + ((i - 63) << 12)), 1'b0);
        for (int i = 1; i < NB; i += 5) req(2'd3, (i < 8) ? 21'(i << 12) : 21'((i - 7) << 15), 1'b0);
        for (int i = 0; i < NB; i++) look((i < 63) ? 21'(i << 15) : 21'(21'h1F8000 + ((i - 63) << 12)), "R1 sweep");
        for (int i = 0; i < NB; i++) look((i < 8) ? 21'(i << 12) : 21'((i - 7) << 15), "R2 sweep");
    endtask

    initial begin
        t_reset_state();
        t_top_edges();
        t_bot_edges();
        t_lock_and_pin();
        t_unlock_rules();
        t_idle();
        t_vpp();
        t_reset_pinned();
        t_sweep();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule